// File: doc/BRIEF.md
# Extended Burst-Mode Handshake Controller

This block is a clocked four-state controller that waits for a complete burst of input edges, then drives an output burst and moves to its next state. It has three inputs, `in_a`, `in_b` and `in_c`, and two level outputs, `out_x` and `out_y`. The inputs are expected to come from synchronisers. The environment must run in fundamental mode: it presents the next input burst only after the previous output burst has appeared.

The block works in two stages. When it enters a state, it latches the three input levels. After that, each input is compared with its latched value. A burst fires only when every input in the burst has moved to its target level. Two extensions are supported:

- `in_b` is a directed don't-care while the controller waits for `in_a` to rise.
- The two exits from the armed state are gated by the level of `in_b`, not by an edge on it.

If an input that does not belong to the pending bursts moves away from its latched value, the controller raises `burst_err` and holds its state.

State encoding and output levels, with state names used below:

| State | out_x | out_y |
|---|---|---|
| WAIT | 0 | 0 |
| ARMED | 0 | 1 |
| CLEARED | 0 | 0 |
| DRAIN | 1 | 0 |

Top module: `xbm_ctrl`

## Requirements
- R1: After reset the controller is in WAIT with `out_x`=0, `out_y`=0 and `burst_err`=0, and it stays there while all inputs are low.
- R2: In WAIT, a rise of `in_a` moves the controller to ARMED, so `out_y` becomes 1 and `out_x` stays 0.
- R3: In WAIT, changes on `in_b` neither fire a transition nor raise `burst_err`. A rise of `in_a` fires whatever `in_b` has done.
- R4: In WAIT a change of `in_c`, in CLEARED a change of `in_a` or `in_b`, and in DRAIN a change of `in_a` or `in_c` each set `burst_err` to 1 and block every transition. `burst_err` returns to 0, and a complete burst may fire, once the offending input is back at its latched level.
- R5: In ARMED with `in_b` high, a rise of `in_c` moves the controller to CLEARED, so `out_y` becomes 0.
- R6: In ARMED, a completed `in_c` rise or `in_a` fall does not fire while `in_b` is low. It fires on the cycle `in_b` is seen high.
- R7: In CLEARED, a fall of `in_c` returns the controller to ARMED, so `out_y` becomes 1.
- R8: In ARMED with `in_b` high, a fall of `in_a` moves the controller to DRAIN, so `out_x` becomes 1 and `out_y` becomes 0 together. `out_x` and `out_y` are never both 1.
- R9: In DRAIN, a fall of `in_b` returns the controller to WAIT, so `out_x` becomes 0.
- R10: Edges are measured against the levels latched on entry to a state. Inputs that stay at the levels that completed the last burst cause no further transition.
- R11: In ARMED, if both `in_a` and `in_c` have changed, `burst_err` is 1 and no transition fires. `in_b` never raises `burst_err` in ARMED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside the block on a clock edge |
| in_a | input | 1 | Synchronised input a |
| in_b | input | 1 | Synchronised input b (burst, don't-care or guard, depending on state) |
| in_c | input | 1 | Synchronised input c |
| out_x | output | 1 | Output x level |
| out_y | output | 1 | Output y level |
| burst_err | output | 1 | An input outside the pending bursts has moved |

## Verification
A burst is judged combinationally from the current inputs and the latched levels, and the state and error flag are registered. Every output therefore shows the result on the first rising edge after the input that completes or breaks a burst. The bench drives inputs on the falling edge, waits for one rising edge and samples 1 ns later, so each check reads the value due at exactly that edge. Where a requirement says nothing may happen, such as a guard held low or a don't-care toggling, the bench holds the stimulus for several edges and checks the outputs after each one.

// File: rtl/xbm_pkg.sv
package xbm_pkg;

  localparam int unsigned IN_W  = 3;
  localparam int unsigned IDX_A = 0;
  localparam int unsigned IDX_B = 1;
  localparam int unsigned IDX_C = 2;

  typedef enum logic [1:0] {
    S_WAIT    = 2'd0,
    S_ARMED   = 2'd1,
    S_CLEARED = 2'd2,
    S_DRAIN   = 2'd3
  } xbm_state_e;

  typedef struct packed {
    logic [IN_W-1:0] mask;
    logic [IN_W-1:0] level;
  } burst_t;

  // Every masked input has moved and now sits at its target level.
  function automatic logic burst_met(input logic [IN_W-1:0] chg,
                                     input logic [IN_W-1:0] now,
                                     input burst_t          bst);
    return ((chg & bst.mask) == bst.mask) &&
           ((now & bst.mask) == (bst.level & bst.mask));
  endfunction

endpackage

// File: rtl/xbm_edge_track.sv
module xbm_edge_track #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] in_vec,
  output logic [W-1:0] chg
);

  logic [W-1:0] ref_q;
  logic [W-1:0] ref_d;

  always_comb begin
    ref_d = ref_q;
    if (load) ref_d = in_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_d;
  end

  assign chg = in_vec ^ ref_q;

  // R10: once latched, an input still at its latched level reports no change
  a_r10_ref_latch: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (chg == (in_vec ^ $past(in_vec))));

endmodule

// File: rtl/xbm_burst_eval.sv
module xbm_burst_eval
  import xbm_pkg::*;
(
  input  xbm_state_e      state,
  input  logic [IN_W-1:0] in_vec,
  input  logic [IN_W-1:0] chg,
  output logic            fire,
  output logic            fault,
  output xbm_state_e      state_d
);

  localparam logic [IN_W-1:0] BIT_A = IN_W'(1) << IDX_A;
  localparam logic [IN_W-1:0] BIT_B = IN_W'(1) << IDX_B;
  localparam logic [IN_W-1:0] BIT_C = IN_W'(1) << IDX_C;

  localparam burst_t B_A_UP = '{mask: BIT_A, level: BIT_A};
  localparam burst_t B_A_DN = '{mask: BIT_A, level: '0};
  localparam burst_t B_C_UP = '{mask: BIT_C, level: BIT_C};
  localparam burst_t B_C_DN = '{mask: BIT_C, level: '0};
  localparam burst_t B_B_DN = '{mask: BIT_B, level: '0};

  logic            guard_b;
  logic [IN_W-1:0] watch;
  logic            conflict;
  logic            met;

  assign guard_b = in_vec[IDX_B];

  always_comb begin
    watch    = '0;
    conflict = 1'b0;
    met      = 1'b0;
    state_d  = state;
    unique case (state)
      S_WAIT: begin
        watch = BIT_C;                       // in_b is a don't-care here
        met   = burst_met(chg, in_vec, B_A_UP);
        state_d = S_ARMED;
      end
      S_ARMED: begin
        conflict = chg[IDX_A] & chg[IDX_C];
        if (burst_met(chg, in_vec, B_A_DN)) begin
          met     = guard_b;
          state_d = S_DRAIN;
        end else if (burst_met(chg, in_vec, B_C_UP)) begin
          met     = guard_b;
          state_d = S_CLEARED;
        end
      end
      S_CLEARED: begin
        watch   = BIT_A | BIT_B;
        met     = burst_met(chg, in_vec, B_C_DN);
        state_d = S_ARMED;
      end
      S_DRAIN: begin
        watch   = BIT_A | BIT_C;
        met     = burst_met(chg, in_vec, B_B_DN);
        state_d = S_WAIT;
      end
      default: state_d = S_WAIT;
    endcase
  end

  assign fault = (|(chg & watch)) | conflict;
  assign fire  = met & ~fault;

endmodule

// File: rtl/xbm_out_decode.sv
module xbm_out_decode
  import xbm_pkg::*;
(
  input  xbm_state_e state,
  output logic       out_x,
  output logic       out_y
);

  always_comb begin
    out_x = 1'b0;
    out_y = 1'b0;
    unique case (state)
      S_ARMED: out_y = 1'b1;
      S_DRAIN: out_x = 1'b1;
      default: ;
    endcase
  end

  // R8: the two outputs are never high together
  a_r8_xy_exclusive: assert final (!(out_x && out_y));

endmodule

// File: rtl/xbm_ctrl.sv
module xbm_ctrl
  import xbm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_a,
  input  logic in_b,
  input  logic in_c,
  output logic out_x,
  output logic out_y,
  output logic burst_err
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [IN_W-1:0] in_vec;
  logic [IN_W-1:0] chg;
  logic            fire;
  logic            fault;
  xbm_state_e      state_q;
  xbm_state_e      state_d;
  logic            err_q;

  always_comb begin
    in_vec        = '0;
    in_vec[IDX_A] = in_a;
    in_vec[IDX_B] = in_b;
    in_vec[IDX_C] = in_c;
  end

  xbm_edge_track #(.W(IN_W)) u_track (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (fire),
    .in_vec (in_vec),
    .chg    (chg)
  );

  xbm_burst_eval u_eval (
    .state   (state_q),
    .in_vec  (in_vec),
    .chg     (chg),
    .fire    (fire),
    .fault   (fault),
    .state_d (state_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= S_WAIT;
      err_q   <= 1'b0;
    end else begin
      if (fire) state_q <= state_d;
      err_q <= fault;
    end
  end

  xbm_out_decode u_dec (
    .state (state_q),
    .out_x (out_x),
    .out_y (out_y)
  );

  assign burst_err = err_q;

  // R4: a flagged input blocks every transition
  a_r4_fault_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault |=> (state_q == $past(state_q)) && burst_err);

  // R3: in WAIT, only a rising in_a can leave; in_b alone never does
  a_r3_wait_needs_a: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == S_WAIT && !in_a) |=> (state_q == S_WAIT));

  // R6: guard low keeps the armed state
  a_r6_guard_level: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == S_ARMED && !in_b) |=> (state_q == S_ARMED));

  // R2: leaving WAIT raises y with x low
  a_r2_wait_exit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == S_WAIT && fire) |=> (out_y && !out_x));

  // R9: leaving DRAIN drops x
  a_r9_drain_exit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == S_DRAIN && fire) |=> (!out_x && !out_y));

endmodule

// File: tb/xbm_ctrl_tb.sv
`timescale 1ns/1ps
module xbm_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_a = 1'b0;
  logic in_b = 1'b0;
  logic in_c = 1'b0;
  logic out_x;
  logic out_y;
  logic burst_err;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;   // 250 MHz

  xbm_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_c      (in_c),
    .out_x     (out_x),
    .out_y     (out_y),
    .burst_err (burst_err)
  );

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic ex, input logic ey,
                           input logic ee);
    check(req, "out_x", out_x, ex);
    check(req, "out_y", out_y, ey);
    check(req, "burst_err", burst_err, ee);
  endtask

  // drive on the falling edge, sample just after the next rising edge
  task automatic apply(input logic a, input logic b, input logic c);
    @(negedge clk);
    in_a = a; in_b = b; in_c = c;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_a = 1'b0; in_b = 1'b0; in_c = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    check_out("R1", 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      apply(1'b0, 1'b0, 1'b0);
      check_out("R1", 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_dont_care();
    do_reset();
    apply(1'b0, 1'b1, 1'b0);
    check_out("R3", 1'b0, 1'b0, 1'b0);
    apply(1'b0, 1'b0, 1'b0);
    check_out("R3", 1'b0, 1'b0, 1'b0);
    apply(1'b1, 1'b1, 1'b0);
    check_out("R2", 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      apply(1'b1, 1'b1, 1'b0);
      check_out("R10", 1'b0, 1'b1, 1'b0);
    end
    apply(1'b1, 1'b0, 1'b0);
    check_out("R11", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_wait_fault();
    do_reset();
    apply(1'b0, 1'b0, 1'b1);
    check_out("R4", 1'b0, 1'b0, 1'b1);
    apply(1'b1, 1'b0, 1'b1);
    check_out("R4", 1'b0, 1'b0, 1'b1);
    apply(1'b1, 1'b0, 1'b0);
    check_out("R4", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_guard_loop();
    do_reset();
    apply(1'b1, 1'b0, 1'b0);
    check_out("R2", 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 2; i++) begin
      apply(1'b1, 1'b0, 1'b1);
      check_out("R6", 1'b0, 1'b1, 1'b0);
    end
    apply(1'b1, 1'b1, 1'b1);
    check_out("R5", 1'b0, 1'b0, 1'b0);
    apply(1'b1, 1'b1, 1'b1);
    check_out("R10", 1'b0, 1'b0, 1'b0);
    apply(1'b0, 1'b1, 1'b1);
    check_out("R4", 1'b0, 1'b0, 1'b1);
    apply(1'b1, 1'b1, 1'b1);
    check_out("R4", 1'b0, 1'b0, 1'b0);
    apply(1'b1, 1'b1, 1'b0);
    check_out("R7", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_exit_path();
    // continues from ARMED with a=1 b=1 c=0 latched
    apply(1'b0, 1'b0, 1'b0);
    check_out("R6", 1'b0, 1'b1, 1'b0);
    apply(1'b0, 1'b1, 1'b0);
    check_out("R8", 1'b1, 1'b0, 1'b0);
    apply(1'b0, 1'b1, 1'b1);
    check_out("R4", 1'b1, 1'b0, 1'b1);
    apply(1'b0, 1'b1, 1'b0);
    check_out("R4", 1'b1, 1'b0, 1'b0);
    apply(1'b0, 1'b0, 1'b0);
    check_out("R9", 1'b0, 1'b0, 1'b0);
    apply(1'b1, 1'b0, 1'b0);
    check_out("R2", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_armed_conflict();
    do_reset();
    apply(1'b1, 1'b1, 1'b0);
    check_out("R2", 1'b0, 1'b1, 1'b0);
    apply(1'b0, 1'b1, 1'b1);
    check_out("R11", 1'b0, 1'b1, 1'b1);
    apply(1'b1, 1'b1, 1'b0);
    check_out("R11", 1'b0, 1'b1, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : main
    t_reset();
    t_dont_care();
    t_wait_fault();
    t_guard_loop();
    t_exit_path();
    t_armed_conflict();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule